// File: doc/BRIEF.md
# Erase Range Walker for a Two-Region Flash Map

This block takes one erase request, a byte address plus a byte length, and checks it against a fixed flash map with two erase regions. The low region is made of small blocks and the high region of large blocks. If the request is well formed, the walker turns it into a sequence of single-block erase requests for a downstream erase engine. It offers one block at a time and waits for that engine to acknowledge each one. When the walk ends, it pulses `done` together with a status code.

By default the map has eight 16 KiB blocks starting at offset 0, followed by thirty-one 128 KiB blocks starting at 128 KiB, for a 4 MiB device. The request is judged in three ways. The start address must be aligned to the block size of its own region. The end address must be aligned to the block size of its own region, and that region is judged separately from the start's. The request must not run past the device end. During the walk the step size changes by itself when the address crosses from the small-block region into the large-block region.

Top module: `erase_range_walker`

## Requirements
- R1: With default parameters, the small-block region spans [0x0, 0x20000) in 0x4000-byte blocks and the large-block region spans [0x20000, 0x400000) in 0x20000-byte blocks. Every `blk_addr` presented with `blk_req` high is aligned to the block size of the region it lies in.
- R2: A non-zero-length request whose start address is not a multiple of its region's block size completes with `done` one cycle after `start` and `status` = 1 (invalid). It issues no block request.
- R3: The end address (start plus length) must be a multiple of the block size of the region it falls in, or the request completes as invalid (status 1). An end equal to 0x20000 belongs to the large-block region.
- R4: A request whose end address exceeds 0x400000 completes as invalid (status 1) with no block request. An end of exactly 0x400000 is accepted.
- R5: A zero-length request completes with `done` one cycle after `start` and `status` = 0 (ok), whatever its address, and issues no block request.
- R6: A valid request presents block addresses in ascending order, starting at the start address. Each next address is the previous one plus the block size of the region the previous one lay in. The number of blocks presented covers exactly the requested length.
- R7: While `blk_req` is high and `blk_ack` is low, `blk_req` stays high and `blk_addr` stays unchanged on the next cycle.
- R8: An acknowledge with `blk_fail` high ends the walk. On the next cycle `blk_req` is low, `done` is high and `status` = 2 (failed), and no further blocks are requested.
- R9: `done` is a single-cycle pulse and is never high together with `blk_req` or `busy`. `busy` is high exactly while a walk is in progress. `start` is ignored while `busy` is high. `status` holds its value until the next completion.
- R10: During and after synchronous active-low reset, `busy`, `done` and `blk_req` are low and `status` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle pulse that submits a request while idle |
| req_addr | input | ADDR_W | First byte of the range to erase |
| req_len | input | ADDR_W | Byte length of the range |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 invalid request, 2 block erase failed |
| blk_req | output | 1 | Block erase request to the erase engine |
| blk_addr | output | ADDR_W | Base address of the requested block |
| blk_ack | input | 1 | Erase engine finished the current block |
| blk_fail | input | 1 | Qualifies `blk_ack`: the block erase failed |

## Verification
The riskiest internal state is the region index carried through the walk. If it advanced early, late or never, the very next `blk_addr` after the 0x20000 boundary would be off by a full block. The bench checks every presented address against a step computed from the address alone. A wrong remaining-length count shows up as a wrong number of blocks at the `done` pulse. A wrong validation decision shows up in the status code one cycle after `start`. Acknowledge latency is varied so that the hold behaviour of the request is seen over several cycles, and a stray `start` is injected mid-walk to show it leaves the address stream untouched.

// File: rtl/erw_pkg.sv
// Shared types for the erase range walker.
// Assumes: status codes are visible at the block's ports and must stay fixed.
package erw_pkg;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_INVALID = 2'd1,
        ST_FAILED  = 2'd2
    } erw_status_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_WALK = 1'b1
    } erw_phase_e;

endpackage

// File: rtl/erw_region_lookup.sv
// Region lookup: says which of the two erase regions an address falls in,
// and whether the address sits on a block boundary of that region.
// Assumes: SPLIT is the first byte of the large-block region; an address
// equal to SPLIT belongs to the large-block region.
module erw_region_lookup #(
    parameter int ADDR_W = 32,
    parameter int SHIFT0 = 14,
    parameter int SHIFT1 = 17,
    parameter logic [ADDR_W:0] SPLIT = '0
) (
    input  logic [ADDR_W:0] addr,
    output logic            rgn,
    output logic            aligned
);

    // Region decision and alignment against that region's block size.
    always_comb begin
        rgn = (addr >= SPLIT);
        if (rgn) begin
            aligned = (addr[SHIFT1-1:0] == '0);
        end else begin
            aligned = (addr[SHIFT0-1:0] == '0);
        end
    end

endmodule

// File: rtl/erw_req_check.sv
// Request checker: judges a (start, length) request in one combinational
// pass. Start and end are each checked against their own region, and the
// end is checked against the device size.
// Assumes: length is unsigned; the sum is formed one bit wider so that it
// cannot wrap.
module erw_req_check #(
    parameter int ADDR_W = 32,
    parameter int SHIFT0 = 14,
    parameter int SHIFT1 = 17,
    parameter logic [ADDR_W:0] SPLIT   = '0,
    parameter logic [ADDR_W:0] DEV_END = '0
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] len,
    output logic              is_zero,
    output logic              is_valid,
    output logic              start_rgn
);

    logic [ADDR_W:0] start_w;
    logic [ADDR_W:0] end_w;
    logic            start_al;
    logic            end_rgn;
    logic            end_al;
    logic            fits;

    // Widen operands and form the exclusive end address.
    always_comb begin
        start_w = {1'b0, addr};
        end_w   = {1'b0, addr} + {1'b0, len};
    end

    erw_region_lookup #(
        .ADDR_W(ADDR_W), .SHIFT0(SHIFT0), .SHIFT1(SHIFT1), .SPLIT(SPLIT)
    ) u_start_lk (
        .addr(start_w), .rgn(start_rgn), .aligned(start_al)
    );

    erw_region_lookup #(
        .ADDR_W(ADDR_W), .SHIFT0(SHIFT0), .SHIFT1(SHIFT1), .SPLIT(SPLIT)
    ) u_end_lk (
        .addr(end_w), .rgn(end_rgn), .aligned(end_al)
    );

    // Only an end in the top region can reach past the device.
    always_comb begin
        fits     = end_rgn ? (end_w <= DEV_END) : 1'b1;
        is_zero  = (len == '0);
        is_valid = start_al && end_al && fits;
    end

endmodule

// File: rtl/erw_stepper.sv
// Walk stepper: holds the current block address, the remaining length and
// the region index. On each step it advances address and length by the
// current region's block size, and moves the region index on at the
// region boundary.
// Assumes: it is loaded only with a validated request, so the remaining
// length is always a whole number of current-region blocks.
module erw_stepper #(
    parameter int ADDR_W = 32,
    parameter int SHIFT0 = 14,
    parameter int SHIFT1 = 17,
    parameter logic [ADDR_W:0] SPLIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              load,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [ADDR_W-1:0] ld_len,
    input  logic              ld_rgn,
    input  logic              step,
    output logic [ADDR_W:0]   cur_addr,
    output logic              last
);

    localparam logic [ADDR_W:0] SIZE0 = (ADDR_W+1)'(1) << SHIFT0;
    localparam logic [ADDR_W:0] SIZE1 = (ADDR_W+1)'(1) << SHIFT1;

    logic [ADDR_W:0] rem_len;
    logic            rgn;
    logic [ADDR_W:0] blk_size;
    logic [ADDR_W:0] nxt_addr;
    logic            lk_rgn;
    logic            lk_al;

    // Step size from the tracked region and the address after this block.
    always_comb begin
        blk_size = rgn ? SIZE1 : SIZE0;
        nxt_addr = cur_addr + blk_size;
        last     = (rem_len == blk_size);
    end

    // Walk registers: load a request, then advance one block per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            rem_len  <= '0;
            rgn      <= 1'b0;
        end else if (load) begin
            cur_addr <= {1'b0, ld_addr};
            rem_len  <= {1'b0, ld_len};
            rgn      <= ld_rgn;
        end else if (step) begin
            cur_addr <= nxt_addr;
            rem_len  <= rem_len - blk_size;
            if (!rgn && (nxt_addr == SPLIT)) begin
                rgn <= 1'b1;
            end
        end
    end

    // Independent region decode of the current address, for checking only.
    erw_region_lookup #(
        .ADDR_W(ADDR_W), .SHIFT0(SHIFT0), .SHIFT1(SHIFT1), .SPLIT(SPLIT)
    ) u_chk_lk (
        .addr(cur_addr), .rgn(lk_rgn), .aligned(lk_al)
    );

    // R6: tracked region index agrees with the address it is stepping.
    assert_rgn_tracks_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rgn == lk_rgn));

    // R1: every block walked lies on a boundary of its own region.
    assert_block_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> lk_al);

    // R6: a non-final step leaves at least one more block of length.
    assert_rem_covers_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> (rem_len > blk_size));

endmodule

// File: rtl/erase_range_walker.sv
// Erase range walker (top): accepts a start/length request while idle,
// validates it against the two-region map, then requests one block erase
// at a time from the erase engine until the range is covered or a block
// fails. Completion is a one-cycle done pulse with a held status code.
// Assumes: blk_fail is only meaningful with blk_ack; the engine handles
// one block at a time.
module erase_range_walker #(
    parameter int ADDR_W    = 32,
    parameter int R0_SHIFT  = 14,
    parameter int R0_BLOCKS = 8,
    parameter int R1_SHIFT  = 17,
    parameter int R1_BLOCKS = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] req_len,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic              blk_req,
    output logic [ADDR_W-1:0] blk_addr,
    input  logic              blk_ack,
    input  logic              blk_fail
);
    import erw_pkg::*;

    localparam logic [ADDR_W:0] R1_BASE = (ADDR_W+1)'(R0_BLOCKS) << R0_SHIFT;
    localparam logic [ADDR_W:0] DEV_END = R1_BASE + ((ADDR_W+1)'(R1_BLOCKS) << R1_SHIFT);

    erw_phase_e      phase;
    logic            done_q;
    erw_status_e     status_q;
    logic            rq_zero;
    logic            rq_valid;
    logic            rq_rgn;
    logic            accept;
    logic            load;
    logic            step;
    logic            st_last;
    logic [ADDR_W:0] cur_addr;

    erw_req_check #(
        .ADDR_W(ADDR_W), .SHIFT0(R0_SHIFT), .SHIFT1(R1_SHIFT),
        .SPLIT(R1_BASE), .DEV_END(DEV_END)
    ) u_check (
        .addr(req_addr), .len(req_len),
        .is_zero(rq_zero), .is_valid(rq_valid), .start_rgn(rq_rgn)
    );

    // Decode when to load the stepper and when to advance it.
    always_comb begin
        accept = (phase == PH_IDLE) && start;
        load   = accept && !rq_zero && rq_valid;
        step   = (phase == PH_WALK) && blk_ack && !blk_fail && !st_last;
    end

    erw_stepper #(
        .ADDR_W(ADDR_W), .SHIFT0(R0_SHIFT), .SHIFT1(R1_SHIFT), .SPLIT(R1_BASE)
    ) u_step (
        .clk(clk), .rst_n(rst_n), .active(phase == PH_WALK),
        .load(load), .ld_addr(req_addr), .ld_len(req_len), .ld_rgn(rq_rgn),
        .step(step), .cur_addr(cur_addr), .last(st_last)
    );

    // Control: phase, completion pulse and held status.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            done_q   <= 1'b0;
            status_q <= ST_OK;
        end else begin
            done_q <= 1'b0;
            if (phase == PH_IDLE) begin
                if (start) begin
                    if (rq_zero) begin
                        done_q   <= 1'b1;
                        status_q <= ST_OK;
                    end else if (!rq_valid) begin
                        done_q   <= 1'b1;
                        status_q <= ST_INVALID;
                    end else begin
                        phase <= PH_WALK;
                    end
                end
            end else if (blk_ack) begin
                if (blk_fail) begin
                    phase    <= PH_IDLE;
                    done_q   <= 1'b1;
                    status_q <= ST_FAILED;
                end else if (st_last) begin
                    phase    <= PH_IDLE;
                    done_q   <= 1'b1;
                    status_q <= ST_OK;
                end
            end
        end
    end

    // Port drive.
    always_comb begin
        busy     = (phase == PH_WALK);
        blk_req  = (phase == PH_WALK);
        blk_addr = cur_addr[ADDR_W-1:0];
        done     = done_q;
        status   = status_q;
    end

    // R7: an unacknowledged request is held with its address.
    assert_req_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req && !blk_ack) |=> (blk_req && $stable(blk_addr)));

    // R9: completion is a single-cycle pulse.
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: no completion while a block is being requested.
    assert_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && (blk_req || busy)));

    // R4: requested blocks stay inside the device.
    assert_in_device_R4: assert property (@(posedge clk) disable iff (!rst_n)
        blk_req |-> (cur_addr < DEV_END));

    // R8: a failed block ends the walk with the failed code.
    assert_fail_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_req && blk_ack && blk_fail) |=> (!blk_req && done && status == 2'd2));

    // R9: status only changes alongside a completion pulse.
    assert_status_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> (done || $stable(status)));

endmodule

// File: tb/erase_range_walker_tb.sv
// Directed bench for the erase range walker: one task per scenario, with a
// small erase-engine responder inside the shared run task.
module erase_range_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_len = '0;
    logic        busy;
    logic        done;
    logic [1:0]  status;
    logic        blk_req;
    logic [31:0] blk_addr;
    logic        blk_ack = 1'b0;
    logic        blk_fail = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    erase_range_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .req_addr(req_addr),
        .req_len(req_len), .busy(busy), .done(done), .status(status),
        .blk_req(blk_req), .blk_addr(blk_addr), .blk_ack(blk_ack),
        .blk_fail(blk_fail)
    );

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Submit one request and act as the erase engine until completion.
    task automatic run_case(input string tag, input logic [31:0] a,
                            input logic [31:0] l, input int fail_idx,
                            input int lat, input bit poke,
                            input int exp_st, input int exp_n);
        logic [31:0] ea = a;
        int n = 0;
        int idle = 0;
        bit fin = 0;
        @(negedge clk);
        start = 1'b1; req_addr = a; req_len = l;
        @(negedge clk);
        start = 1'b0;
        while (!fin) begin
            if (done) begin
                check(tag, "status", status, exp_st);
                check(tag, "blocks erased", n, exp_n);
                check("R9", "busy at done", busy, 0);
                check("R8", "request at done", blk_req, 0);
                @(negedge clk);
                check("R9", "done pulse width", done, 0);
                check("R9", "status held", status, exp_st);
                fin = 1;
            end else if (blk_req) begin
                check(tag, "block address", blk_addr, ea);
                check("R9", "busy while walking", busy, 1);
                for (int k = 0; k < lat; k++) begin
                    if (poke && k == 0) begin
                        start = 1'b1; req_addr = 32'h0000_0123; req_len = 32'h4000;
                    end
                    @(negedge clk);
                    start = 1'b0;
                    check("R7", "request held", {blk_req, blk_addr}, {1'b1, ea});
                end
                blk_ack = 1'b1;
                blk_fail = (n == fail_idx);
                @(negedge clk);
                blk_ack = 1'b0;
                blk_fail = 1'b0;
                n++;
                ea = ea + ((ea < 32'h0002_0000) ? 32'h0000_4000 : 32'h0002_0000);
            end else begin
                @(negedge clk);
                idle++;
                if (idle > 50) begin
                    check(tag, "walk stalled", 0, 1);
                    fin = 1;
                end
            end
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R10", "busy in reset", busy, 0);
        check("R10", "done in reset", done, 0);
        check("R10", "blk_req in reset", blk_req, 0);
        check("R10", "status in reset", status, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", "idle after reset", {busy, done, blk_req}, 0);
    endtask

    task automatic t_zero_len();
        run_case("R5", 32'h0000_0123, 32'h0, -1, 0, 0, 0, 0);
        run_case("R5", 32'h0010_0000, 32'h0, -1, 0, 0, 0, 0);
    endtask

    task automatic t_single_small();
        run_case("R6", 32'h0000_4000, 32'h0000_4000, -1, 1, 0, 0, 1);
    endtask

    task automatic t_cross_boundary();
        // 0x18000..0x40000: two small blocks then one large block (R1, R6).
        run_case("R6", 32'h0001_8000, 32'h0002_8000, -1, 0, 0, 0, 3);
    endtask

    task automatic t_bad_start();
        run_case("R2", 32'h0000_2000, 32'h0000_4000, -1, 0, 0, 1, 0);
        run_case("R2", 32'h0002_4000, 32'h0002_0000, -1, 0, 0, 1, 0);
    endtask

    task automatic t_bad_end();
        run_case("R3", 32'h0001_8000, 32'h0001_8000, -1, 0, 0, 1, 0);
        // End exactly on the large-region start: accepted, four small blocks.
        run_case("R3", 32'h0001_0000, 32'h0001_0000, -1, 0, 0, 0, 4);
    endtask

    task automatic t_device_end();
        run_case("R4", 32'h003E_0000, 32'h0004_0000, -1, 0, 0, 1, 0);
        run_case("R4", 32'h003E_0000, 32'h0002_0000, -1, 2, 0, 0, 1);
    endtask

    task automatic t_fail_mid();
        run_case("R8", 32'h0000_0000, 32'h0001_4000, 2, 1, 0, 2, 3);
    endtask

    task automatic t_busy_ignore();
        run_case("R9", 32'h0001_8000, 32'h0002_8000, -1, 3, 1, 0, 3);
    endtask

    task automatic t_whole_device();
        run_case("R1", 32'h0000_0000, 32'h0040_0000, -1, 0, 0, 0, 39);
    endtask

    initial begin
        t_reset();
        t_zero_len();
        t_single_small();
        t_cross_boundary();
        t_bad_start();
        t_bad_end();
        t_device_end();
        t_fail_mid();
        t_busy_ignore();
        t_whole_device();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule